// File: doc/BRIEF.md
# Signed Adder-Subtractor with Condition Flags

This block adds or subtracts two two's-complement operands of a parameterised width (32 bits by default). Subtraction reuses the adder: the second operand is bit-inverted and a carry-in of one is injected. The result is available in the same cycle that the operands are applied.

A four-flag condition register holds negative, zero, overflow and carry. It loads from the current operation only on a clock edge where the flag-load strobe is high, and it clears on reset. Overflow comes from comparing the signs of the two adder inputs with the sign of the sum; the carry-out is never used for it. A greater-than-zero branch decision is taken from the stored flags.

The second operand can also come from a narrower input. That input is sign-extended to the full width before it enters the adder.

Top module: `arith_flag_unit`

## Requirements
- R1: In add mode (`subSel`=0) `result` equals `opA + opB` modulo 2^DATA_W, with the carry out of the top bit dropped. `result` is valid in the same cycle as the inputs.
- R2: In subtract mode (`subSel`=1) `result` equals `opA` plus the bit-inverted second operand plus one. This equals `opA - opB` modulo 2^DATA_W.
- R3: The carry flag is the raw carry out of the adder. There is no borrow inversion, so 5-3 gives C=1, 3-5 gives C=0 and 0xFFFFFFFF+1 gives C=1.
- R4: The overflow flag is set only when both adder inputs have the same sign bit and the sum's sign bit differs from it. In subtract mode the second adder input is the inverted operand. Cases: 0x7FFFFFFF+1 sets V with C=0, and 0x80000000+0x80000000 sets V with C=1. Mixed-sign additions never set V.
- R5: The negative flag equals bit DATA_W-1 of the result. The zero flag is set when every result bit is 0.
- R6: The stored flags load only on a rising clock edge where `flagWe`=1 and hold otherwise. Asserting `rstN` low clears all four flags at once.
- R7: `branchGtz` is 1 exactly when the stored negative and zero flags are both 0.
- R8: When `useNarrowB`=1 the second operand is `opBNarrow` with its bit NARROW_W-1 copied into every upper position, and `opB` has no effect. For example, 16-bit 0xFFFB acts as -5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the flag register |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Full-width second operand |
| opBNarrow | input | NARROW_W | Narrow second operand, sign-extended before use |
| useNarrowB | input | 1 | 1 selects `opBNarrow` as the second operand |
| subSel | input | 1 | 0 = add, 1 = subtract |
| flagWe | input | 1 | Load the flag register on this clock edge |
| result | output | DATA_W | Sum or difference |
| flagNeg | output | 1 | Stored negative flag |
| flagZero | output | 1 | Stored zero flag |
| flagOvf | output | 1 | Stored overflow flag |
| flagCarry | output | 1 | Stored carry flag |
| branchGtz | output | 1 | Greater-than-zero decision from stored flags |

## Verification
The clocked assertions assume that `opA`, `opB`, `opBNarrow`, `subSel`, `useNarrowB` and `flagWe` are known (not X) and steady around each rising edge once reset is released. The bench therefore changes all inputs only on the falling edge, and it holds every input at a defined value from time zero. The bench also pulses reset on the falling edge and never releases it near a rising edge, so the hold and load properties see only clean flag-register transitions.

// File: rtl/arith_flag_pkg.sv
`timescale 1ns/1ps
package arith_flag_pkg;

  // Strobes from the control to the datapath for one operation
  typedef struct packed {
    logic invertB;       // feed the complement of the second operand
    logic carryIn;       // inject +1 at the adder LSB
    logic captureFlags;  // load the condition register at the next edge
    logic selNarrow;     // take the sign-extended narrow operand
  } ctrlStrobe_t;

  // Stored condition code
  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } ccFlags_t;

endpackage

// File: rtl/arith_flag_ctrl.sv
`timescale 1ns/1ps
module arith_flag_ctrl
  import arith_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        subSel,
  input  logic        flagWe,
  input  logic        useNarrowB,
  input  logic        storedNeg,
  input  logic        storedZero,
  output ctrlStrobe_t strobe,
  output logic        branchGtz
);

  // Subtract = add complement plus one: both strobes follow the op select
  always_comb begin
    strobe.invertB      = subSel;
    strobe.carryIn      = subSel;
    strobe.captureFlags = flagWe;
    strobe.selNarrow    = useNarrowB;
  end

  // Greater than zero: neither negative nor zero
  always_comb branchGtz = ~(storedNeg | storedZero);

  AST_BRANCH_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    storedZero |-> !branchGtz);  // R7
  AST_BRANCH_ON_NEG: assert property (@(posedge clk) disable iff (!rstN)
    storedNeg |-> !branchGtz);  // R7

endmodule

// File: rtl/arith_flag_datapath.sv
`timescale 1ns/1ps
module arith_flag_datapath
  import arith_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [NARROW_W-1:0] opBNarrow,
  input  ctrlStrobe_t         strobe,
  output logic [DATA_W-1:0]   result,
  output ccFlags_t            ccQ
);

  localparam int MSB = DATA_W - 1;
  localparam int EXT_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] narrowExt;
  logic [DATA_W-1:0] bSel;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   wideSum;
  logic [DATA_W-1:0] sumBits;
  ccFlags_t          ccNext;

  // Sign extension of the narrow operand; variant picked by width
  generate
    if (EXT_W > 0) begin : g_extend
      assign narrowExt = {{EXT_W{opBNarrow[NARROW_W-1]}}, opBNarrow};
    end else begin : g_same
      assign narrowExt = opBNarrow[DATA_W-1:0];
    end
  endgenerate

  always_comb bSel = strobe.selNarrow ? narrowExt : opB;
  always_comb bEff = strobe.invertB ? ~bSel : bSel;

  // Single adder, carry out kept in the extra bit
  always_comb wideSum = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strobe.carryIn};
  always_comb sumBits = wideSum[MSB:0];
  always_comb result  = sumBits;

  // Flags for the current operation
  always_comb begin
    ccNext.neg   = sumBits[MSB];
    ccNext.zero  = ~|sumBits;
    ccNext.ovf   = (opA[MSB] == bEff[MSB]) && (sumBits[MSB] != opA[MSB]);
    ccNext.carry = wideSum[DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    ccQ <= '0;
    else if (strobe.captureFlags) ccQ <= ccNext;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (opA[MSB] != bEff[MSB]) |-> !ccNext.ovf);  // R4
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.invertB && strobe.carryIn) |-> (sumBits == DATA_W'(opA - bSel)));  // R2
  AST_NARROW_EXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selNarrow |-> ($signed(bSel) == $signed(opBNarrow)));  // R8
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureFlags |=> $stable(ccQ));  // R6
  AST_CC_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureFlags |=> (ccQ.zero == ($past(result) == '0)));  // R5

endmodule

// File: rtl/arith_flag_unit.sv
`timescale 1ns/1ps
module arith_flag_unit
  import arith_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [NARROW_W-1:0] opBNarrow,
  input  logic                useNarrowB,
  input  logic                subSel,
  input  logic                flagWe,
  output logic [DATA_W-1:0]   result,
  output logic                flagNeg,
  output logic                flagZero,
  output logic                flagOvf,
  output logic                flagCarry,
  output logic                branchGtz
);

  ctrlStrobe_t strobe;
  ccFlags_t    ccQ;

  arith_flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .subSel     (subSel),
    .flagWe     (flagWe),
    .useNarrowB (useNarrowB),
    .storedNeg  (ccQ.neg),
    .storedZero (ccQ.zero),
    .strobe     (strobe),
    .branchGtz  (branchGtz)
  );

  arith_flag_datapath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .opBNarrow (opBNarrow),
    .strobe    (strobe),
    .result    (result),
    .ccQ       (ccQ)
  );

  assign flagNeg   = ccQ.neg;
  assign flagZero  = ccQ.zero;
  assign flagOvf   = ccQ.ovf;
  assign flagCarry = ccQ.carry;

endmodule

// File: tb/tb_arith_flag_unit.sv
`timescale 1ns/1ps
module tb_arith_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] opBNarrow = '0;
  logic        useNarrowB = 1'b0;
  logic        subSel = 1'b0;
  logic        flagWe = 1'b0;
  logic [31:0] result;
  logic        flagNeg, flagZero, flagOvf, flagCarry, branchGtz;

  int checks = 0;
  int failures = 0;
  logic [3:0] expCc = 4'b0;  // {N,Z,V,C}

  arith_flag_unit dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opBNarrow(opBNarrow),
    .useNarrowB(useNarrowB), .subSel(subSel), .flagWe(flagWe),
    .result(result), .flagNeg(flagNeg), .flagZero(flagZero),
    .flagOvf(flagOvf), .flagCarry(flagCarry), .branchGtz(branchGtz)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkStored(input string tagNote);
    checkVal("R5", {tagNote, " N"}, 32'(flagNeg), 32'(expCc[3]));
    checkVal("R5", {tagNote, " Z"}, 32'(flagZero), 32'(expCc[2]));
    checkVal("R4", {tagNote, " V"}, 32'(flagOvf), 32'(expCc[1]));
    checkVal("R3", {tagNote, " C"}, 32'(flagCarry), 32'(expCc[0]));
    checkVal("R7", {tagNote, " branchGtz"}, 32'(branchGtz),
             32'(!expCc[3] && !expCc[2]));
  endtask

  // One operation: drive on falling edge, check result, then flags after the edge
  task automatic runOp(input string resTag, input logic [31:0] a, input logic [31:0] b,
                       input logic sub, input logic [15:0] nb, input logic narrow,
                       input logic we);
    longint as, bs, exact;
    logic [63:0] bU, sumU;
    logic [31:0] expRes;
    logic expC, expV;
    @(negedge clk);
    opA = a; opB = b; subSel = sub; opBNarrow = nb; useNarrowB = narrow; flagWe = we;
    #1;
    as = longint'($signed(a));
    bs = narrow ? longint'($signed(nb)) : longint'($signed(b));
    bU = 64'(bs) & 64'hFFFF_FFFF;
    exact = sub ? as - bs : as + bs;
    expRes = exact[31:0];
    expV = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
    sumU = {32'b0, a} + bU;
    expC = sub ? ({32'b0, a} >= bU) : sumU[32];
    checkVal(resTag, "result", result, expRes);
    @(posedge clk);
    #1;
    if (we) expCc = {expRes[31], expRes == 32'b0, expV, expC};
    flagWe = 1'b0;
    checkStored(we ? "loaded" : "held R6");
  endtask

  task automatic tReset();
    #1;
    checkStored("reset R6");
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tAdd();
    runOp("R1", 32'd3, 32'd4, 1'b0, 16'h0, 1'b0, 1'b1);
    runOp("R1", 32'hFFFF_FFFF, 32'd1, 1'b0, 16'h0, 1'b0, 1'b1);     // wrap, C=1 Z=1
    runOp("R1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b1); // mixed sign, C=1 V=0
  endtask

  task automatic tOverflow();
    runOp("R4", 32'h7FFF_FFFF, 32'd1, 1'b0, 16'h0, 1'b0, 1'b1);     // V=1 C=0
    runOp("R4", 32'h8000_0000, 32'h8000_0000, 1'b0, 16'h0, 1'b0, 1'b1); // V=1 C=1
    runOp("R4", 32'h8000_0000, 32'd1, 1'b1, 16'h0, 1'b0, 1'b1);      // sub overflow
    runOp("R4", 32'h0, 32'h8000_0000, 1'b1, 16'h0, 1'b0, 1'b1);      // 0 - min
  endtask

  task automatic tSub();
    runOp("R2", 32'd5, 32'd3, 1'b1, 16'h0, 1'b0, 1'b1);   // C=1
    runOp("R2", 32'd3, 32'd5, 1'b1, 16'h0, 1'b0, 1'b1);   // N=1 C=0
    runOp("R2", 32'h1234_5678, 32'h1234_5678, 1'b1, 16'h0, 1'b0, 1'b1); // Z=1 C=1
  endtask

  task automatic tHold();
    runOp("R1", 32'd10, 32'd20, 1'b0, 16'h0, 1'b0, 1'b1);
    runOp("R2", 32'd0, 32'd0, 1'b1, 16'h0, 1'b0, 1'b0);   // would set Z, must not load
    runOp("R1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic tNarrow();
    runOp("R8", 32'd10, 32'hDEAD_BEEF, 1'b0, 16'hFFFB, 1'b1, 1'b1);  // 10 + (-5)
    runOp("R8", 32'd1, 32'h0000_0001, 1'b0, 16'h7FFF, 1'b1, 1'b1);   // positive ext
    runOp("R8", 32'd0, 32'h1111_1111, 1'b1, 16'h8000, 1'b1, 1'b1);   // 0 - (-32768)
  endtask

  task automatic tMidReset();
    runOp("R2", 32'd3, 32'd5, 1'b1, 16'h0, 1'b0, 1'b1);  // N set
    @(negedge clk); rstN = 1'b0;
    #1;
    expCc = 4'b0;
    checkStored("async reset R6");
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    tAdd();
    tSub();
    tOverflow();
    tHold();
    tNarrow();
    tMidReset();
    runOp("R1", 32'd1, 32'd1, 1'b0, 16'h0, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule